// File: doc/BRIEF.md
# Four-Channel PWM Generator

This block produces four pulse-width modulated outputs from one shared period counter. The counter advances on ticks of a power-of-two clock divider. It runs in one of two shapes. In edge-aligned mode it counts up and wraps. In center-aligned mode it counts up to the top value and then back down. Each channel output is high while the count is below that channel's compare value.

New compare values arrive as samples on a valid/ready stream. A sample carries four 16-bit fields. The block holds one sample in a shadow slot and copies it into the active registers only at a period boundary, so the outputs never change shape in the middle of a period.

The back-pressure rules are simple. `smp_ready` is high while the shadow slot is empty. A sample is taken on a clock edge where `smp_valid` and `smp_ready` are both high. `smp_ready` then stays low until the period boundary that consumes the sample. A sender may hold `smp_valid` high for as long as it needs to. A waveform-flagged sample uses its fourth field as the period top instead of as a compare value. An upstream sequencer uses this to change frequency sample by sample. A single-cycle `period_end` pulse marks each boundary.

Top module: `pwm_quad`

## Requirements
- R1: After reset the outputs and `period_end` are low, `smp_ready` is high, the count is 0 and the active top is 1000. With `presc`=0, the first `period_end` follows the enabling edge by 1001 clock cycles, whatever `top_in` holds.
- R2: One count step lasts 2^`presc` clock cycles, with `presc` a 3-bit code from 0 (divide by 1) to 7 (divide by 128).
- R3: With `center`=0 and top T, a period is T+1 steps (count 0..T, then wrap to 0). A channel with compare C is high for min(C, T+1) steps per period.
- R4: With `center`=1 and top T≥1, a period is 2T steps (0 up to T, then down to 1). A channel with compare C is high for 0 steps when C=0, and otherwise for min(2C-1, 2T) steps.
- R5: A 16-bit top with bit 15 set, from `top_in` or from a waveform field, acts as 32767.
- R6: Channel i's compare is bits [16i+14:16i] of `smp_data`; bit 16i+15 has no effect.
- R7: `period_end` is high for exactly one clock cycle per period, in the cycle after the step that wraps the count to 0.
- R8: A sample is accepted when `smp_valid` and `smp_ready` are both high, and `smp_ready` is low from the next cycle until the cycle in which `period_end` is high. The accepted values, and `top_in`, take effect only from that boundary.
- R9: A sample accepted with `wave_mode`=1 sets the top from bits [63:48] and drives channel 3 low. Channels 0 to 2 use their fields. A later sample with `wave_mode`=0 returns the top to `top_in`.
- R10: While `en` is low, the count freezes, the outputs hold their last level and `period_end` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable for divider, counter and outputs |
| center | input | 1 | 1 selects center-aligned counting, 0 selects edge-aligned |
| presc | input | 3 | Divider code; a step lasts 2^presc cycles |
| top_in | input | 16 | Period top, sampled at each boundary; clamps to 32767 |
| wave_mode | input | 1 | Marks the sample being offered as a waveform sample |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Shadow slot empty, sample can be taken |
| smp_data | input | 64 | Four 16-bit fields; field i at bits [16i+15:16i] |
| pwm_out | output | 4 | Channel outputs, bit i is channel i |
| period_end | output | 1 | One-cycle pulse per completed period |

## Verification
The stimulus covers edge-aligned periods with compare values of zero, mid-range, exactly T+1 and above the top. This separates an off-by-one in the wrap point from a comparator that uses the wrong relation. The same compares in center-aligned mode, including C equal to T, show whether the turnaround counts the top once and the bottom once. Divide codes 2 and 7 are compared against divide 1 at equal top to isolate the divider. Samples with bit 15 set, a waveform sample and the sample after it, an all-ones top and a disable taken while outputs are high separate masking, top override, restoration, clamping and hold behaviour.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;

  localparam int unsigned DEF_CHANNELS  = 4;
  localparam int unsigned DEF_VAL_W     = 15;
  localparam int unsigned DEF_PRESC_W   = 3;
  localparam int unsigned DEF_RESET_TOP = 1000;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] code,
  output logic          tick
);
  localparam int CW = (1 << PW) - 1;

  logic [CW-1:0] phase;
  logic [CW-1:0] mask;

  // low 'code' bits of the mask are set; a tick fires when they all are set in phase
  always_comb begin
    for (int i = 0; i < CW; i++) begin
      mask[i] = (PW'(i) < code);
    end
  end

  assign tick = en && ((phase & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (en) begin
      phase <= phase + CW'(1);
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_quad_pkg::*;
#(
  parameter int VW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          center,
  input  logic [VW-1:0] top,
  output logic [VW-1:0] cnt,
  output logic          boundary
);
  cnt_dir_e      dir, dir_n;
  logic [VW-1:0] cnt_n;

  always_comb begin
    cnt_n    = cnt;
    dir_n    = dir;
    boundary = 1'b0;
    if (tick) begin
      if (!center) begin
        dir_n = DIR_UP;
        if (cnt >= top) begin
          cnt_n    = '0;
          boundary = 1'b1;
        end else begin
          cnt_n = cnt + VW'(1);
        end
      end else if (dir == DIR_UP) begin
        if (cnt >= top) begin
          if (top <= VW'(1)) begin
            cnt_n    = '0;
            boundary = 1'b1;
          end else begin
            cnt_n = top - VW'(1);
            dir_n = DIR_DOWN;
          end
        end else begin
          cnt_n = cnt + VW'(1);
        end
      end else begin
        if (cnt <= VW'(1)) begin
          cnt_n    = '0;
          dir_n    = DIR_UP;
          boundary = 1'b1;
        end else begin
          cnt_n = cnt - VW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      dir <= DIR_UP;
    end else begin
      cnt <= cnt_n;
      dir <= dir_n;
    end
  end
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int CH        = 4,
  parameter int VW        = 15,
  parameter int RESET_TOP = 1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_valid,
  output logic                   smp_ready,
  input  logic [CH*(VW+1)-1:0]   smp_data,
  input  logic                   wave_in,
  input  logic [VW:0]            top_in,
  input  logic                   boundary,
  output logic [CH-1:0][VW-1:0]  cmp_act,
  output logic [VW-1:0]          top_act
);
  localparam int FW = VW + 1;

  function automatic logic [VW-1:0] clamp_top(input logic [FW-1:0] v);
    return v[FW-1] ? {VW{1'b1}} : v[VW-1:0];
  endfunction

  logic [CH-1:0][VW-1:0] fld_cmp;
  logic [CH-1:0]         msb_unused;
  logic [CH-1:0][VW-1:0] shd_cmp;
  logic [VW-1:0]         shd_top;
  logic                  shd_wave;
  logic                  pending;
  logic                  wave_act;
  logic                  accept;

  always_comb begin
    for (int i = 0; i < CH; i++) begin
      fld_cmp[i]    = smp_data[i*FW +: VW];
      msb_unused[i] = smp_data[i*FW + VW];
    end
  end

  assign smp_ready = !pending;
  assign accept    = smp_valid && !pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      wave_act <= 1'b0;
      shd_cmp  <= '0;
      shd_top  <= '0;
      shd_wave <= 1'b0;
      cmp_act  <= '0;
      top_act  <= VW'(RESET_TOP);
    end else begin
      if (accept) begin
        shd_cmp  <= fld_cmp;
        shd_top  <= clamp_top(smp_data[(CH-1)*FW +: FW]);
        shd_wave <= wave_in;
        pending  <= 1'b1;
      end else if (boundary) begin
        pending  <= 1'b0;
      end

      if (boundary) begin
        if (pending) begin
          cmp_act  <= shd_cmp;
          wave_act <= shd_wave;
          if (shd_wave) begin
            cmp_act[CH-1] <= '0;
            top_act       <= shd_top;
          end else begin
            top_act <= clamp_top(top_in);
          end
        end else if (!wave_act) begin
          top_act <= clamp_top(top_in);
        end
      end
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int VW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [VW-1:0] cnt,
  input  logic [VW-1:0] cmp,
  output logic          out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out <= 1'b0;
    end else if (en) begin
      out <= (cnt < cmp);
    end
  end
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int CHANNELS  = DEF_CHANNELS,
  parameter int VW        = DEF_VAL_W,
  parameter int PW        = DEF_PRESC_W,
  parameter int RESET_TOP = DEF_RESET_TOP
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       center,
  input  logic [PW-1:0]              presc,
  input  logic [VW:0]                top_in,
  input  logic                       wave_mode,
  input  logic                       smp_valid,
  output logic                       smp_ready,
  input  logic [CHANNELS*(VW+1)-1:0] smp_data,
  output logic [CHANNELS-1:0]        pwm_out,
  output logic                       period_end
);
  logic                        tick;
  logic                        boundary;
  logic [VW-1:0]               cnt;
  logic [VW-1:0]               top_act;
  logic [CHANNELS-1:0][VW-1:0] cmp_act;

  pwm_prescaler #(.PW(PW)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .code (presc),
    .tick (tick)
  );

  pwm_counter #(.VW(VW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .center  (center),
    .top     (top_act),
    .cnt     (cnt),
    .boundary(boundary)
  );

  pwm_shadow #(.CH(CHANNELS), .VW(VW), .RESET_TOP(RESET_TOP)) u_shd (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .smp_ready(smp_ready),
    .smp_data (smp_data),
    .wave_in  (wave_mode),
    .top_in   (top_in),
    .boundary (boundary),
    .cmp_act  (cmp_act),
    .top_act  (top_act)
  );

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    pwm_channel #(.VW(VW)) u_ch (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .cnt  (cnt),
      .cmp  (cmp_act[g]),
      .out  (pwm_out[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_end <= 1'b0;
    end else begin
      period_end <= boundary;
    end
  end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
  parameter int CHANNELS = 4,
  parameter int PW       = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic [PW-1:0]       presc,
  input logic                smp_valid,
  input logic                smp_ready,
  input logic [CHANNELS-1:0] pwm_out,
  input logic                period_end
);
  // R7: with a divider above 1 held steady, boundaries are at least two cycles apart
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && presc != '0 && $stable(presc)) |=> !period_end);

  // R10: disabled block neither moves its outputs nor reports a period end
  a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(pwm_out) && !period_end));

  // R8: an accepted sample fills the slot
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);

  // R8: the slot only empties at a period boundary
  a_r8_ready_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_ready) |-> period_end);

  // R10: a period end needs the block enabled on the step before it
  a_r10_end_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> $past(en));
endmodule

bind pwm_quad pwm_quad_chk #(.CHANNELS(CHANNELS), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .presc     (presc),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .pwm_out   (pwm_out),
  .period_end(period_end)
);

// File: tb/tb_pwm_quad.sv
module tb_pwm_quad;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        center = 1'b0;
  logic [2:0]  presc = 3'd0;
  logic [15:0] top_in = 16'd10;
  logic        wave_mode = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [63:0] smp_data = '0;
  logic [3:0]  pwm_out;
  logic        period_end;

  always #10 clk = ~clk;

  pwm_quad dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .center    (center),
    .presc     (presc),
    .top_in    (top_in),
    .wave_mode (wave_mode),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_data  (smp_data),
    .pwm_out   (pwm_out),
    .period_end(period_end)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    int    len;
    int    h0;
    int    h1;
    int    h2;
    int    h3;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [63:0] pack4(input int a, input int b, input int c, input int d);
    return {d[15:0], c[15:0], b[15:0], a[15:0]};
  endfunction

  task automatic load(input logic [63:0] d, input bit w);
    @(negedge clk);
    while (!smp_ready) @(negedge clk);
    smp_data  = d;
    wave_mode = w;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    wave_mode = 1'b0;
  endtask

  // driver side of the scoreboard: queue one expected period and wait for the monitor
  task automatic expect_period(input int len, input int a, input int b, input int c,
                               input int d, input string tag);
    exp_t e;
    e.len = len; e.h0 = a; e.h1 = b; e.h2 = c; e.h3 = d; e.tag = tag;
    exp_q.push_back(e);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: skip one settling period, then measure one full period and compare
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        int   seen;
        int   len;
        int   hc[4];
        exp_t e;
        seen = 0;
        while (seen < 2) begin
          @(negedge clk);
          if (period_end) seen++;
        end
        len = 0;
        for (int c = 0; c < 4; c++) hc[c] = 0;
        do begin
          @(negedge clk);
          len++;
          for (int c = 0; c < 4; c++) if (pwm_out[c]) hc[c]++;
        end while (!period_end);
        e = exp_q[0];
        chk({e.tag, " period"}, len, e.len);
        chk({e.tag, " ch0"}, hc[0], e.h0);
        chk({e.tag, " ch1"}, hc[1], e.h1);
        chk({e.tag, " ch2"}, hc[2], e.h2);
        chk({e.tag, " ch3"}, hc[3], e.h3);
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    int bad;
    logic [3:0] snap;

    repeat (3) @(negedge clk);
    chk("R1 pwm_out after reset", int'(pwm_out), 0);
    chk("R1 period_end after reset", int'(period_end), 0);
    chk("R1 smp_ready after reset", int'(smp_ready), 1);
    rst_n = 1'b1;

    load(pack4(3, 5, 0, 20), 1'b0);
    chk("R8 ready low after accept", int'(smp_ready), 0);

    // R1: first period uses the reset top of 1000, not top_in
    en = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!period_end);
    chk("R1 first period cycles", n, 1001);
    chk("R8 ready back at boundary", int'(smp_ready), 1);

    expect_period(11, 3, 5, 0, 11, "R3 up top10");

    load(pack4(16'h8004, 16'h8000, 7, 11), 1'b0);
    expect_period(11, 4, 0, 7, 11, "R6 msb ignored");

    presc = 3'd2;
    expect_period(44, 16, 0, 28, 44, "R2 div4");

    // R7: pulse width and pulse count over a fixed window
    do @(negedge clk); while (!period_end);
    @(negedge clk);
    chk("R7 pulse one cycle", int'(period_end), 0);
    n = 0;
    for (int k = 0; k < 440; k++) begin
      @(negedge clk);
      if (period_end) n++;
    end
    chk("R7 pulses in 440 cycles", n, 10);

    presc = 3'd7;
    expect_period(1408, 512, 0, 896, 1408, "R2 div128");
    presc = 3'd0;

    center = 1'b1;
    expect_period(20, 7, 0, 13, 20, "R4 center a");
    load(pack4(10, 1, 5, 30), 1'b0);
    expect_period(20, 19, 1, 9, 20, "R4 center b");
    center = 1'b0;

    load(pack4(2, 6, 9, 5), 1'b1);
    expect_period(6, 2, 6, 6, 0, "R9 waveform top");
    load(pack4(1, 1, 1, 1), 1'b0);
    expect_period(11, 1, 1, 1, 1, "R9 top restored");

    // R10: disable while outputs are high
    load(pack4(5, 5, 5, 5), 1'b0);
    do @(negedge clk); while (!period_end);
    do @(negedge clk); while (!period_end);
    while (!pwm_out[0]) @(negedge clk);
    en = 1'b0;
    snap = pwm_out;
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pwm_out != snap || period_end) bad++;
    end
    chk("R10 hold while disabled", bad, 0);
    chk("R10 held level", int'(pwm_out), 15);
    en = 1'b1;
    expect_period(11, 5, 5, 5, 5, "R10 resume");

    top_in = 16'hFFFF;
    load(pack4(100, 0, 0, 0), 1'b0);
    expect_period(32768, 100, 0, 0, 0, "R5 top clamp");

    summary();
    $finish;
  end
endmodule